// File: doc/BRIEF.md
# Instruction Trap Condition Detector

This block sits beside the instruction decoder of a 16-bit processor core and decides, for every decoded instruction, whether that instruction raises a synchronous exception. When one does, the block reports which vector type is taken. It also reports the byte offset into the vector table and the return address that the stack-push logic must save. The decoder presents the opcode byte with a strobe, along with the execution-side conditions: divide fault, overflow flag, single-step flag, and the index and bounds of a bound check. It also presents the addresses needed to form a return address and two configuration bits that govern escape opcodes.

All results are registered. A trap appears as a single-cycle pulse in the clock cycle after the decode strobe. When several conditions hold on one instruction, exactly one trap is reported.

Escape opcodes are treated by a mode rule. In compatible mode they always trap. In enhanced mode they trap only when the escape-trap enable is set. Faulting traps return to the start of the instruction, and that start includes a segment override prefix when one was present.

Top module: `trap_detect`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `trap_valid` is 0 and `trap_type`, `trap_offset` and `trap_ret_addr` are all 0.
- R2: A decoded instruction with `div_fault` set raises vector type 0.
- R3: Opcode CEh (interrupt on overflow) raises type 4 when `ovf_flag` is 1. It raises no trap when `ovf_flag` is 0.
- R4: Opcode 62h (bound check) raises type 5 when the signed 16-bit `bnd_index` is less than `bnd_lower` or greater than `bnd_upper`. An index equal to either bound raises nothing.
- R5: The undefined opcodes 0Fh, 63h, 64h, 65h, 66h, 67h and F1h raise type 6.
- R6: Escape opcodes D8h through DFh raise type 7 when `enh_mode` is 0 (compatible mode). When `enh_mode` is 1 they raise type 7 only if `esc_trap_en` is 1.
- R7: Opcode CCh (one-byte breakpoint) raises type 3, and `trap_offset` is then 12.
- R8: `step_flag` raises type 1 only when no other condition of R2 to R7 holds on the same instruction.
- R9: When several of the conditions of R2 to R7 hold at once, the lowest type number is reported, and only one trap is reported.
- R10: `trap_offset` equals the reported type multiplied by 4, as a 10-bit value.
- R11: For types 0, 5, 6 and 7, `trap_ret_addr` is `pfx_addr` when `pfx_seen` is 1 and `instr_addr` otherwise. For types 1, 3 and 4 it is `next_addr`.
- R12: `trap_valid` is high for exactly the one cycle after a `dec_valid` cycle whose instruction traps, and never otherwise. Whenever `trap_valid` is 0, `trap_type`, `trap_offset` and `trap_ret_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | A decoded instruction is presented this cycle |
| opcode | input | 8 | Opcode byte of the decoded instruction |
| instr_addr | input | ADDR_W (20) | Address of the opcode byte |
| next_addr | input | ADDR_W (20) | Address of the following instruction |
| pfx_seen | input | 1 | A segment override prefix preceded the opcode |
| pfx_addr | input | ADDR_W (20) | Address of that prefix |
| ovf_flag | input | 1 | Current overflow flag |
| div_fault | input | 1 | Divide unit reports quotient overflow or divide by zero |
| step_flag | input | 1 | Single-step trap is armed |
| bnd_index | input | IDX_W (16) | Signed index under bound check |
| bnd_lower | input | IDX_W (16) | Signed lower bound |
| bnd_upper | input | IDX_W (16) | Signed upper bound |
| enh_mode | input | 1 | 0 for compatible mode, 1 for enhanced mode |
| esc_trap_en | input | 1 | In enhanced mode, makes escape opcodes trap |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_type | output | 8 | Vector type of the trap |
| trap_offset | output | 10 | Vector table byte offset |
| trap_ret_addr | output | ADDR_W (20) | Return address to save |

## Verification
Several rules are checked by assertions on every cycle:
- the trap pulse follows a decode strobe;
- outputs are zero while idle;
- a divide fault always wins;
- a compatible-mode escape always traps;
- a disabled enhanced-mode escape and a clear-overflow CEh stay silent;
- the breakpoint offset is 12.

Only the bench's scenarios can show the remaining behaviour. This covers the signed bound edges, where an index equal to a bound or one step beyond it decides the result. It also covers the full priority ordering under random mixes of conditions, the single-step fallback, and the choice of return address between prefix, opcode and next instruction.

// File: rtl/trap_det_pkg.sv
package trap_det_pkg;

    localparam int NUM_TYPES = 8;

    localparam logic [7:0] OP_BRKPT  = 8'hCC;
    localparam logic [7:0] OP_OVFCHK = 8'hCE;
    localparam logic [7:0] OP_BNDCHK = 8'h62;

    localparam int T_DIV   = 0;
    localparam int T_STEP  = 1;
    localparam int T_BRK   = 3;
    localparam int T_OVF   = 4;
    localparam int T_BND   = 5;
    localparam int T_UNDEF = 6;
    localparam int T_ESC   = 7;

    function automatic logic is_undef_op(input logic [7:0] op);
        return (op == 8'h0F) || (op >= 8'h63 && op <= 8'h67) || (op == 8'hF1);
    endfunction

    function automatic logic is_esc_op(input logic [7:0] op);
        return op[7:3] == 5'b11011;
    endfunction

endpackage

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
    import trap_det_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic [7:0]           opcode,
    input  logic                 ovf_flag,
    input  logic                 div_fault,
    input  logic [IDX_W-1:0]     bnd_index,
    input  logic [IDX_W-1:0]     bnd_lower,
    input  logic [IDX_W-1:0]     bnd_upper,
    input  logic                 enh_mode,
    input  logic                 esc_trap_en,
    output logic [NUM_TYPES-1:0] fault_hit
);
    logic below_lo;
    logic above_hi;
    logic esc_armed;

    always_comb begin
        below_lo  = $signed(bnd_index) < $signed(bnd_lower);
        above_hi  = $signed(bnd_index) > $signed(bnd_upper);
        esc_armed = !enh_mode || esc_trap_en;

        fault_hit          = '0;
        fault_hit[T_DIV]   = div_fault;
        fault_hit[T_BRK]   = (opcode == OP_BRKPT);
        fault_hit[T_OVF]   = (opcode == OP_OVFCHK) && ovf_flag;
        fault_hit[T_BND]   = (opcode == OP_BNDCHK) && (below_lo || above_hi);
        fault_hit[T_UNDEF] = is_undef_op(opcode);
        fault_hit[T_ESC]   = is_esc_op(opcode) && esc_armed;
    end
endmodule

// File: rtl/trap_prio_sel.sv
module trap_prio_sel
    import trap_det_pkg::*;
#(
    parameter int VT_W = 8
) (
    input  logic [NUM_TYPES-1:0] fault_hit,
    input  logic                 step_hit,
    output logic                 any_hit,
    output logic [VT_W-1:0]      sel_type
);
    always_comb begin
        any_hit  = 1'b0;
        sel_type = '0;
        for (int i = NUM_TYPES - 1; i >= 0; i--) begin
            if (fault_hit[i]) begin
                any_hit  = 1'b1;
                sel_type = VT_W'(i);
            end
        end
        if (!any_hit && step_hit) begin
            any_hit  = 1'b1;
            sel_type = VT_W'(T_STEP);
        end
    end
endmodule

// File: rtl/trap_ret_sel.sv
module trap_ret_sel
    import trap_det_pkg::*;
#(
    parameter int VT_W   = 8,
    parameter int ADDR_W = 20
) (
    input  logic [VT_W-1:0]   sel_type,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              pfx_seen,
    input  logic [ADDR_W-1:0] pfx_addr,
    output logic [ADDR_W-1:0] ret_addr
);
    logic restart;
    logic [ADDR_W-1:0] start_addr;

    always_comb begin
        restart    = (sel_type == VT_W'(T_DIV))   || (sel_type == VT_W'(T_BND)) ||
                     (sel_type == VT_W'(T_UNDEF)) || (sel_type == VT_W'(T_ESC));
        start_addr = pfx_seen ? pfx_addr : instr_addr;
        ret_addr   = restart ? start_addr : next_addr;
    end
endmodule

// File: rtl/trap_detect.sv
module trap_detect
    import trap_det_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 16,
    parameter int VT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              pfx_seen,
    input  logic [ADDR_W-1:0] pfx_addr,
    input  logic              ovf_flag,
    input  logic              div_fault,
    input  logic              step_flag,
    input  logic [IDX_W-1:0]  bnd_index,
    input  logic [IDX_W-1:0]  bnd_lower,
    input  logic [IDX_W-1:0]  bnd_upper,
    input  logic              enh_mode,
    input  logic              esc_trap_en,
    output logic              trap_valid,
    output logic [VT_W-1:0]   trap_type,
    output logic [VT_W+1:0]   trap_offset,
    output logic [ADDR_W-1:0] trap_ret_addr
);
    localparam int OFF_W = VT_W + 2;

    typedef struct packed {
        logic              valid;
        logic [VT_W-1:0]   vtype;
        logic [OFF_W-1:0]  voff;
        logic [ADDR_W-1:0] ret;
    } trap_out_t;

    trap_out_t out_d, out_q;

    logic [NUM_TYPES-1:0] fault_hit;
    logic                 any_hit;
    logic [VT_W-1:0]      sel_type;
    logic [ADDR_W-1:0]    sel_ret;

    trap_cond_eval #(.IDX_W(IDX_W)) u_eval (
        .opcode      (opcode),
        .ovf_flag    (ovf_flag),
        .div_fault   (div_fault),
        .bnd_index   (bnd_index),
        .bnd_lower   (bnd_lower),
        .bnd_upper   (bnd_upper),
        .enh_mode    (enh_mode),
        .esc_trap_en (esc_trap_en),
        .fault_hit   (fault_hit)
    );

    trap_prio_sel #(.VT_W(VT_W)) u_prio (
        .fault_hit (fault_hit),
        .step_hit  (step_flag),
        .any_hit   (any_hit),
        .sel_type  (sel_type)
    );

    trap_ret_sel #(.VT_W(VT_W), .ADDR_W(ADDR_W)) u_ret (
        .sel_type   (sel_type),
        .instr_addr (instr_addr),
        .next_addr  (next_addr),
        .pfx_seen   (pfx_seen),
        .pfx_addr   (pfx_addr),
        .ret_addr   (sel_ret)
    );

    always_comb begin
        out_d = '0;
        if (dec_valid && any_hit) begin
            out_d.valid = 1'b1;
            out_d.vtype = sel_type;
            out_d.voff  = {sel_type, 2'b00};
            out_d.ret   = sel_ret;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign trap_valid    = out_q.valid;
    assign trap_type     = out_q.vtype;
    assign trap_offset   = out_q.voff;
    assign trap_ret_addr = out_q.ret;
endmodule

// File: rtl/trap_detect_chk.sv
module trap_detect_chk #(
    parameter int VT_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            dec_valid,
    input logic [7:0]      opcode,
    input logic            ovf_flag,
    input logic            div_fault,
    input logic            step_flag,
    input logic            enh_mode,
    input logic            esc_trap_en,
    input logic            trap_valid,
    input logic [VT_W-1:0] trap_type,
    input logic [VT_W+1:0] trap_offset
);
    logic esc_op;
    assign esc_op = opcode[7:3] == 5'b11011;

    // R12
    pulse_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> $past(dec_valid));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |-> (trap_type == '0 && trap_offset == '0));

    // R2
    div_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && div_fault) |=> (trap_valid && trap_type == '0));

    // R3
    ovf_clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && opcode == 8'hCE && !ovf_flag && !div_fault && !step_flag) |=> !trap_valid);

    // R6
    esc_compat_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && esc_op && !enh_mode && !div_fault) |=> (trap_valid && trap_type == VT_W'(7)));

    // R6
    esc_enh_off_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && esc_op && enh_mode && !esc_trap_en && !div_fault && !step_flag) |=> !trap_valid);

    // R7
    brk_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && opcode == 8'hCC && !div_fault) |=> (trap_type == VT_W'(3) && trap_offset == 10'd12));
endmodule

bind trap_detect trap_detect_chk #(.VT_W(VT_W)) u_trap_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .opcode      (opcode),
    .ovf_flag    (ovf_flag),
    .div_fault   (div_fault),
    .step_flag   (step_flag),
    .enh_mode    (enh_mode),
    .esc_trap_en (esc_trap_en),
    .trap_valid  (trap_valid),
    .trap_type   (trap_type),
    .trap_offset (trap_offset)
);

// File: tb/trap_detect_bench.sv
module trap_detect_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          dec_valid;
    logic [7:0]    opcode;
    logic [AW-1:0] instr_addr, next_addr, pfx_addr;
    logic          pfx_seen, ovf_flag, div_fault, step_flag;
    logic [15:0]   bnd_index, bnd_lower, bnd_upper;
    logic          enh_mode, esc_trap_en;
    logic          trap_valid;
    logic [7:0]    trap_type;
    logic [9:0]    trap_offset;
    logic [AW-1:0] trap_ret_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_detect u_trap_detect (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .opcode(opcode),
        .instr_addr(instr_addr), .next_addr(next_addr), .pfx_seen(pfx_seen),
        .pfx_addr(pfx_addr), .ovf_flag(ovf_flag), .div_fault(div_fault),
        .step_flag(step_flag), .bnd_index(bnd_index), .bnd_lower(bnd_lower),
        .bnd_upper(bnd_upper), .enh_mode(enh_mode), .esc_trap_en(esc_trap_en),
        .trap_valid(trap_valid), .trap_type(trap_type),
        .trap_offset(trap_offset), .trap_ret_addr(trap_ret_addr)
    );

    // expected type, or -1 when nothing traps
    function automatic int exp_type();
        if (!dec_valid) return -1;
        if (div_fault) return 0;
        if (opcode == 8'hCC) return 3;
        if (opcode == 8'hCE && ovf_flag) return 4;
        if (opcode == 8'h62 && ($signed(bnd_index) < $signed(bnd_lower) ||
                                $signed(bnd_index) > $signed(bnd_upper))) return 5;
        if (opcode == 8'h0F || opcode == 8'hF1 || (opcode >= 8'h63 && opcode <= 8'h67)) return 6;
        if (opcode >= 8'hD8 && opcode <= 8'hDF && (!enh_mode || esc_trap_en)) return 7;
        if (step_flag) return 1;
        return -1;
    endfunction

    function automatic logic [AW-1:0] exp_ret(input int t);
        if (t == 0 || t == 5 || t == 6 || t == 7) return pfx_seen ? pfx_addr : instr_addr;
        return next_addr;
    endfunction

    function automatic string tag_of(input int t);
        case (t)
            0: return "R2";
            1: return "R8";
            3: return "R7";
            4: return "R3";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dec_valid = 0; opcode = 8'h90; instr_addr = '0; next_addr = '0;
        pfx_seen = 0; pfx_addr = '0; ovf_flag = 0; div_fault = 0; step_flag = 0;
        bnd_index = '0; bnd_lower = '0; bnd_upper = '0; enh_mode = 0; esc_trap_en = 0;
    endtask

    // inputs already driven at a falling edge; result checked at the next one
    task automatic run_one(input string extra);
        int t;
        logic [AW-1:0] r;
        t = exp_type();
        r = exp_ret(t);
        @(negedge clk);
        if (t < 0) begin
            chk({extra, " R12 valid"}, 32'(trap_valid), 32'd0);
            chk({extra, " R12 zero"}, {trap_type, 14'd0, trap_offset}, 32'd0);
        end else begin
            chk({extra, " ", tag_of(t), " valid"}, 32'(trap_valid), 32'd1);
            chk({extra, " ", tag_of(t), " R9 type"}, 32'(trap_type), 32'(t));
            chk({extra, " R10 offset"}, 32'(trap_offset), 32'(t * 4));
            chk({extra, " R11 ret"}, 32'(trap_ret_addr), 32'(r));
        end
    endtask

    task automatic base(input logic [7:0] op);
        idle_inputs();
        dec_valid = 1; opcode = op;
        instr_addr = 20'h1_0010; next_addr = 20'h1_0012; pfx_addr = 20'h1_000F;
    endtask

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 valid", 32'(trap_valid), 32'd0);
        chk("R1 outs", {trap_type, 14'd0, trap_offset}, 32'd0);
        chk("R1 ret", 32'(trap_ret_addr), 32'd0);
        rst = 0;
        run_one("R1 post");

        base(8'h90); div_fault = 1; run_one("R2 div");
        base(8'hCE); ovf_flag = 1; run_one("R3 ovf set");
        base(8'hCE); ovf_flag = 0; run_one("R3 ovf clear");
        base(8'h62); bnd_lower = 16'hFFF6; bnd_upper = 16'd5;
        bnd_index = 16'hFFF6; run_one("R4 eq lower");
        base(8'h62); bnd_lower = 16'hFFF6; bnd_upper = 16'd5;
        bnd_index = 16'd5; run_one("R4 eq upper");
        base(8'h62); bnd_lower = 16'hFFF6; bnd_upper = 16'd5;
        bnd_index = 16'hFFF5; run_one("R4 below");
        base(8'h62); bnd_lower = 16'hFFF6; bnd_upper = 16'd5;
        bnd_index = 16'd6; run_one("R4 above");
        base(8'h62); bnd_lower = 16'd0; bnd_upper = 16'h7FFF;
        bnd_index = 16'h8000; run_one("R4 signed");
        base(8'h0F); run_one("R5 0F");
        base(8'h67); run_one("R5 67");
        base(8'hF1); run_one("R5 F1");
        base(8'hD8); enh_mode = 0; run_one("R6 compat");
        base(8'hDF); enh_mode = 1; esc_trap_en = 0; run_one("R6 enh off");
        base(8'hDB); enh_mode = 1; esc_trap_en = 1; pfx_seen = 1; run_one("R6 R11 prefix");
        base(8'hCC); run_one("R7 brk");
        base(8'h90); step_flag = 1; run_one("R8 step alone");
        base(8'hCC); step_flag = 1; run_one("R8 step masked");
        base(8'h0F); div_fault = 1; step_flag = 1; run_one("R9 div+undef");
        base(8'hCC); dec_valid = 0; run_one("R12 no strobe");
        base(8'hCC); run_one("R12 first");
        idle_inputs(); run_one("R12 after");

        for (int k = 0; k < 3000; k++) begin
            logic [7:0] pick[12];
            pick = '{8'hCC, 8'hCE, 8'h62, 8'h0F, 8'h63, 8'h65, 8'hF1,
                     8'hD8, 8'hDD, 8'hDF, 8'h90, 8'h00};
            idle_inputs();
            dec_valid   = ($urandom % 8) != 0;
            opcode      = ($urandom % 4 == 0) ? 8'($urandom) : pick[$urandom % 12];
            instr_addr  = 20'($urandom);
            next_addr   = 20'($urandom);
            pfx_addr    = 20'($urandom);
            pfx_seen    = 1'($urandom);
            ovf_flag    = 1'($urandom);
            div_fault   = ($urandom % 10) == 0;
            step_flag   = ($urandom % 5) == 0;
            bnd_lower   = 16'($signed(16'($urandom % 64)) - 16'sd32);
            bnd_upper   = 16'($signed(bnd_lower) + 16'sd20);
            bnd_index   = 16'($signed(bnd_lower) + 16'($urandom % 32) - 16'sd6);
            enh_mode    = 1'($urandom);
            esc_trap_en = 1'($urandom);
            run_one("rand");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R12 actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule